// File: doc/BRIEF.md
# Offset-Binary Audio Byte to One-Bit Delta-Sigma Output

This block turns a stream of 8-bit mono audio bytes, each marked by a one-cycle valid strobe (for instance from a serial receiver at roughly 11 kHz), into a single-bit pulse-density signal. An external RC filter can turn that signal back into sound. Each byte is coded offset-binary: code 0 is the most negative level, 128 is silence and 255 is the top of the scale. The block turns the byte into two's-complement by flipping its top bit. It scales the result by a 3-bit volume code and feeds it to a first-order delta-sigma modulator that runs on every system clock.

The captured sample is held and repeated until the next strobe arrives, so the modulator never starves between bytes. The modulator bit passes through one more flip-flop before it reaches the left pin. The right pin is held at a fixed idle level. With the default parameters, the ones density on the left pin over any 1024 consecutive cycles with constant input is exactly (scaled level + 512) / 1024.

Top module: `pcm_dsm_out`

## Requirements
- R1: A byte present while `smp_vld` is high is captured at that clock edge and kept unchanged, and repeated to the modulator, until the next strobe.
- R2: Offset-binary conversion flips only bit 7, so code 128 is level 0, code 0 is level -128 and code 255 is level +127.
- R3: The scaled level is floor(level * vol / 4), using an arithmetic shift, so volume code 4 is unity gain. The volume input acts continuously, with no strobe needed.
- R4: Volume code 0 yields a scaled level of 0, and therefore a 50% ones density, whatever the sample.
- R5: With a constant scaled level L, every window of 1024 consecutive cycles on `aud_left` holds exactly L + 512 ones. At L = 0 the pin alternates every cycle.
- R6: `aud_left` is registered one cycle behind the modulator bit. After reset is released with a silent level, the pin is first high on the third rising edge that sees `rst_n` high.
- R7: `aud_right` stays at the idle level (logic 0) at all times.
- R8: Synchronous active-low reset sets the held sample to mid-scale (level 0), clears the accumulator and drives `aud_left` low. Reset wins over a strobe in the same cycle.
- R9: When strobes arrive on consecutive cycles, the later byte is the one held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | One-cycle strobe marking a new sample byte |
| smp_byte | input | 8 | Offset-binary audio sample |
| vol | input | 3 | Volume code, 4 = unity gain, 0 = mute |
| aud_left | output | 1 | Registered pulse-density audio output |
| aud_right | output | 1 | Unused channel, held idle low |

## Verification
Three events can land on the same clock edge: a sample strobe together with reset, two strobes on back-to-back edges, and a strobe together with a volume change. The bench raises the strobe carrying code 255 while reset is still low, then releases reset. It judges the result by the ones count over a full 1024-cycle window, which must read the mid-scale 512 rather than the 255 value. It also drives codes 0 and 255 on adjacent edges and expects the density of the second byte. Because the count over a full window is exact for a first-order loop, a single-unit error in the conversion, scaling or offset shows up as a wrong count.

// File: rtl/pcm_dsm_pkg.sv
// Package: shared widths for the offset-binary to delta-sigma path.
// Assumes a gain of one at volume code 2**VOL_SHIFT.
package pcm_dsm_pkg;
    parameter int SMP_W     = 8;   // sample byte width
    parameter int VOL_W     = 3;   // volume code width
    parameter int VOL_SHIFT = 2;   // right shift after the multiply
    // product width: signed sample times zero-extended volume
    parameter int PROD_W    = SMP_W + VOL_W + 1;
    // width of the scaled signed level fed to the modulator
    parameter int LVL_W     = PROD_W - VOL_SHIFT;
endpackage

// File: rtl/pcm_capture.sv
// Module: pcm_capture
// Holds the most recent sample byte and converts it from offset binary to
// two's complement by flipping the top bit. Assumes the strobe is one cycle
// per byte; the held value is reused until the next strobe.
module pcm_capture #(
    parameter int W = pcm_dsm_pkg::SMP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld,
    input  logic [W-1:0]        code,
    output logic signed [W-1:0] level
);

    // latch and convert the byte on its strobe; reset to mid-scale (zero)
    always_ff @(posedge clk) begin
        if (!rst_n)
            level <= '0;
        else if (vld)
            level <= {~code[W-1], code[W-2:0]};
    end

    // R1: without a strobe the held level does not move
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(level));

    // R2: only the top bit differs from the captured code
    p_msb_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> (level[W-1] != $past(code[W-1])) &&
                (level[W-2:0] == $past(code[W-2:0])));

    // R8: reset leaves the held sample at mid-scale
    p_reset_mid_r8: assert property (@(posedge clk)
        !rst_n |=> level == '0);

endmodule

// File: rtl/pcm_vol_scale.sv
// Module: pcm_vol_scale
// Multiplies the signed level by an unsigned volume code and applies a fixed
// arithmetic right shift, registering the result. Assumes the shift makes code
// 2**SHIFT unity gain; code 0 mutes.
module pcm_vol_scale #(
    parameter int W     = pcm_dsm_pkg::SMP_W,
    parameter int VW    = pcm_dsm_pkg::VOL_W,
    parameter int SHIFT = pcm_dsm_pkg::VOL_SHIFT,
    parameter int PW    = W + VW + 1,
    parameter int LW    = PW - SHIFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [W-1:0]  level,
    input  logic [VW-1:0]        vol,
    output logic signed [LW-1:0] scaled
);

    logic signed [PW-1:0] lvl_ext;
    logic signed [PW-1:0] vol_ext;
    logic signed [PW-1:0] prod;

    // widen both operands and form the full product
    always_comb begin
        lvl_ext = {{(PW-W){level[W-1]}}, level};
        vol_ext = {{(PW-VW){1'b0}}, vol};
        prod    = lvl_ext * vol_ext;
    end

    // register the shifted product; reset gives silence
    always_ff @(posedge clk) begin
        if (!rst_n)
            scaled <= '0;
        else
            scaled <= LW'(prod >>> SHIFT);
    end

    // R4: a zero volume code gives a zero level
    p_mute_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vol == '0 |=> scaled == '0);

    // R3: a negative sample with non-zero volume stays negative
    p_neg_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level[W-1] && vol != '0) |=> scaled[LW-1]);

    // R3: a non-negative sample never yields a negative level
    p_pos_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !level[W-1] |=> !scaled[LW-1]);

endmodule

// File: rtl/dsm_first_order.sv
// Module: dsm_first_order
// First-order delta-sigma modulator. The signed level is offset to unsigned
// by flipping its top bit, added to the accumulator, and the carry out is the
// output bit. Assumes the level is held for many cycles relative to 2**LW.
module dsm_first_order #(
    parameter int LW = pcm_dsm_pkg::LVL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [LW-1:0] lvl,
    output logic                 bit_q
);

    logic [LW-1:0] acc;
    logic [LW-1:0] lvl_u;
    logic [LW:0]   sum;

    // offset the level by half scale and add with a carry bit
    always_comb begin
        lvl_u = {~lvl[LW-1], lvl[LW-2:0]};
        sum   = {1'b0, acc} + {1'b0, lvl_u};
    end

    // keep the residue and emit the carry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            bit_q <= 1'b0;
        end else begin
            acc   <= sum[LW-1:0];
            bit_q <= sum[LW];
        end
    end

    // R5: a held zero level makes the bit alternate every cycle
    p_mid_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && lvl == '0 && $past(lvl) == '0)
        |=> bit_q != $past(bit_q));

    // R8: reset clears the output bit
    p_bit_reset_r8: assert property (@(posedge clk)
        !rst_n |=> !bit_q);

endmodule

// File: rtl/pcm_dsm_out.sv
// Module: pcm_dsm_out
// Top level: captures offset-binary bytes, scales them by volume, modulates
// to one bit and registers the bit onto the left pin. The right pin is held
// idle. Assumes a single clock domain for the strobe and the modulator.
module pcm_dsm_out #(
    parameter int   SMP_W     = pcm_dsm_pkg::SMP_W,
    parameter int   VOL_W     = pcm_dsm_pkg::VOL_W,
    parameter int   VOL_SHIFT = pcm_dsm_pkg::VOL_SHIFT,
    parameter logic IDLE_LVL  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [SMP_W-1:0] smp_byte,
    input  logic [VOL_W-1:0] vol,
    output logic             aud_left,
    output logic             aud_right
);

    localparam int PW = SMP_W + VOL_W + 1;
    localparam int LW = PW - VOL_SHIFT;

    logic signed [SMP_W-1:0] held_lvl;
    logic signed [LW-1:0]    scaled_lvl;
    logic                    mod_bit;

    pcm_capture #(.W(SMP_W)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .vld   (smp_vld),
        .code  (smp_byte),
        .level (held_lvl)
    );

    pcm_vol_scale #(.W(SMP_W), .VW(VOL_W), .SHIFT(VOL_SHIFT), .PW(PW), .LW(LW))
    u_scale (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (held_lvl),
        .vol    (vol),
        .scaled (scaled_lvl)
    );

    dsm_first_order #(.LW(LW)) u_dsm (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (scaled_lvl),
        .bit_q (mod_bit)
    );

    // retime the modulator bit onto the pin
    always_ff @(posedge clk) begin
        if (!rst_n)
            aud_left <= 1'b0;
        else
            aud_left <= mod_bit;
    end

    // unused channel held at its idle level
    assign aud_right = IDLE_LVL;

endmodule

// File: tb/test_pcm_dsm_out.sv
module test_pcm_dsm_out;
    localparam int WIN = 1024;
    localparam int MID = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0;
    logic [7:0] smp_byte = 8'd0;
    logic [2:0] vol = 3'd4;
    logic       aud_left;
    logic       aud_right;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pcm_dsm_out i_pcm_dsm_out (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_byte(smp_byte),
        .vol(vol), .aud_left(aud_left), .aud_right(aud_right)
    );

    function automatic int exp_ones(input int code, input int v);
        int s;
        int p;
        s = code - 128;
        p = s * v;
        return (p >>> 2) + MID;
    endfunction

    task automatic check(input string req, input int act, input int exp, input int tol);
        n_chk++;
        if (act > exp + tol || act < exp - tol) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; smp_vld = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input int code, input int v);
        @(negedge clk);
        vol = 3'(v); smp_byte = 8'(code); smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic measure(input string req, input int exp);
        int cnt = 0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (aud_left) cnt++;
            if (aud_right !== 1'b0) cnt = -100000;
        end
        check(req, cnt, exp, 1);
    endtask

    // reset state and the first-high timing after release
    task automatic t_reset_timing();
        rst_n = 1'b0; vol = 3'd4;
        repeat (3) @(negedge clk);
        check("R8 pin low in reset", int'(aud_left), 0, 0);
        check("R7 right idle", int'(aud_right), 0, 0);
        rst_n = 1'b1;
        @(negedge clk); check("R6 edge1", int'(aud_left), 0, 0);
        @(negedge clk); check("R6 edge2", int'(aud_left), 0, 0);
        @(negedge clk); check("R6 edge3", int'(aud_left), 1, 0);
        @(negedge clk); check("R6 edge4", int'(aud_left), 0, 0);
        measure("R8 mid after reset", MID);
    endtask

    // silent code toggles every cycle
    task automatic t_mid_toggle();
        int toggles = 0;
        logic prev;
        send(128, 4);
        repeat (8) @(negedge clk);
        prev = aud_left;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (aud_left != prev) toggles++;
            prev = aud_left;
        end
        check("R5 alternation", toggles, 20, 0);
    endtask

    task automatic t_levels();
        send(128, 4); measure("R2 code128", exp_ones(128, 4));
        send(0, 4);   measure("R2 code0", exp_ones(0, 4));
        send(255, 4); measure("R2 code255", exp_ones(255, 4));
        send(255, 7); measure("R3 vol7 top", exp_ones(255, 7));
        send(0, 7);   measure("R3 vol7 bottom", exp_ones(0, 7));
        send(200, 2); measure("R3 vol2", exp_ones(200, 2));
        send(1, 3);   measure("R3 vol3 floor", exp_ones(1, 3));
    endtask

    task automatic t_mute();
        send(0, 0);   measure("R4 mute low code", MID);
        send(255, 0); measure("R4 mute high code", MID);
    endtask

    // held sample repeats; volume acts without a strobe
    task automatic t_hold();
        send(30, 4);
        measure("R1 held first", exp_ones(30, 4));
        repeat (300) @(negedge clk);
        measure("R1 held later", exp_ones(30, 4));
        @(negedge clk); vol = 3'd6;
        measure("R3 volume without strobe", exp_ones(30, 6));
    endtask

    task automatic t_back_to_back();
        @(negedge clk); vol = 3'd4; smp_byte = 8'd0; smp_vld = 1'b1;
        @(negedge clk); smp_byte = 8'd255;
        @(negedge clk); smp_vld = 1'b0;
        measure("R9 last strobe wins", exp_ones(255, 4));
    endtask

    task automatic t_strobe_in_reset();
        send(0, 4);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); smp_byte = 8'd255; smp_vld = 1'b1;
        @(negedge clk); smp_vld = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        measure("R8 reset beats strobe", MID);
    endtask

    initial begin
        #3_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_timing();
        t_mid_toggle();
        t_levels();
        t_mute();
        t_hold();
        t_back_to_back();
        t_strobe_in_reset();
        do_reset();
        check("R7 right idle end", int'(aud_right), 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule